// File: doc/BRIEF.md
# Folded multi-bank wavelet FIR convolver

This block computes one output of a long FIR filter whose coefficients stand for a dilated wavelet. The filter is folded in time: five multipliers are reused over many fast-clock cycles. Each cycle five buffered samples meet five coefficients, and the five products are added into a running sum until every tap of the chosen filter has been used. A circular buffer keeps the incoming 16-bit samples. Coefficients come from a bank of selectable symmetric sets, of which only the first half of each is stored. The address logic reflects tap positions past the middle back onto the stored half.

Samples arrive on a valid strobe. To use the block, a controller writes samples, then pulses start with a set index and a tap count. A single-cycle valid later marks the scaled 16-bit result. The fast clock must be fast enough that a whole computation ends before the next sample is needed. A start that arrives while a computation is running is dropped.

Top module: `wavelet_fir_conv`

## Requirements
- R1: After synchronous reset, `result_valid` is low and stays low until a start is accepted.
- R2: The result is the exact sum over taps j = 0..T-1 of x[j]*c[j], shifted right arithmetically by 11 and truncated to its low 16 bits. x[0] is the newest sample written before the cycle that accepts start, and x[j] is the sample written j strobes earlier.
- R3: Stored half-coefficient k of set s is the low 12 bits, read as signed, of 29*s + 7*k*k + 3*k + 5. Tap j uses index j when 2j+1 <= T and T-1-j otherwise, so the centre tap of an odd-length filter is used once.
- R4: `result_valid` is high for exactly one cycle. It is high ceil(T/5) clock edges after the edge that accepts start (minimum 1).
- R5: A start while a computation is running has no effect on the running result, its latency or its set.
- R6: When T is not a multiple of five, lanes past T in the last group add nothing.
- R7: Filters of up to 200 taps with full-scale samples and coefficients never overflow the accumulator.
- R8: Samples written during a computation do not change that computation's result.
- R9: The set index selects among 121 distinct coefficient sets (indices 0 to 120).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast processing clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_valid | input | 1 | Write strobe for sample_in |
| sample_in | input | 16 | Signed sample |
| start | input | 1 | Request to compute one output |
| set_sel | input | 7 | Coefficient set index |
| tap_count | input | 8 | Number of taps T (1 to 200) |
| result_valid | output | 1 | One-cycle result strobe |
| result | output | 16 | Scaled signed result |

## Verification
Every cycle, the assertions check that the result strobe is a single-cycle pulse that follows a running computation. They also check that set, length and buffer origin stay frozen while a computation runs, and that mirrored coefficient addresses stay in the stored half. They further check that the accumulator guard bits always agree with its sign, and that the group counter never passes the tap count. Only the bench's scenarios can show that the numeric result matches the convolution. The same goes for the mirroring of odd and even lengths, the masking of partial groups, the choice of set, and insensitivity to stray starts and late samples. The bench measures each of these against an independent model.

// File: rtl/wfir_pkg.sv
package wfir_pkg;
    localparam int SAMPLE_W = 16;
    localparam int COEF_W   = 12;
    localparam int LANES    = 5;
    localparam int FRAC_SH  = 11;

    typedef logic signed [SAMPLE_W-1:0]        sample_t;
    typedef logic signed [COEF_W-1:0]          coef_t;
    typedef logic signed [SAMPLE_W+COEF_W-1:0] prod_t;

    typedef enum logic { ST_IDLE, ST_RUN } state_e;

    typedef struct packed {
        logic    en;
        sample_t smp;
        coef_t   cf;
    } lane_t;

    function automatic coef_t half_coef(input int unsigned set_idx, input int unsigned k);
        int unsigned t;
        t = 29 * set_idx + 7 * k * k + 3 * k + 5;
        return coef_t'(t[COEF_W-1:0]);
    endfunction
endpackage

// File: rtl/wfir_sample_buf.sv
module wfir_sample_buf
    import wfir_pkg::*;
#(
    parameter int PTR_W = 9,
    parameter int OFS_W = 9
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  sample_t                         wr_data,
    output logic [PTR_W-1:0]                newest,
    input  logic [PTR_W-1:0]                base,
    input  logic [LANES-1:0][OFS_W-1:0]     offs,
    output logic [LANES-1:0][SAMPLE_W-1:0]  rd
);
    localparam int DEPTH = 2 ** PTR_W;

    sample_t           mem [DEPTH];
    logic [PTR_W-1:0]  wptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr <= '0;
        end else if (wr_en) begin
            mem[wptr] <= wr_data;
            wptr      <= wptr + 1'b1;
        end
    end

    assign newest = wptr - 1'b1;

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        logic [PTR_W-1:0] addr;
        assign addr  = base - PTR_W'(offs[l]);
        assign rd[l] = mem[addr];
    end
endmodule

// File: rtl/wfir_coef_rom.sv
module wfir_coef_rom
    import wfir_pkg::*;
#(
    parameter int SET_W  = 7,
    parameter int HALF_W = 7
) (
    input  logic [SET_W-1:0]               set_sel,
    input  logic [LANES-1:0][HALF_W-1:0]   addr,
    output logic [LANES-1:0][COEF_W-1:0]   coef
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign coef[l] = half_coef(32'(set_sel), 32'(addr[l]));
    end
endmodule

// File: rtl/wfir_mac.sv
module wfir_mac
    import wfir_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int HEAD_W = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clear,
    input  logic                     acc_en,
    input  lane_t [LANES-1:0]        lanes,
    output logic signed [ACC_W-1:0]  acc
);
    localparam int PW    = SAMPLE_W + COEF_W;
    localparam int GUARD = PW - 1 + HEAD_W;

    prod_t                   prod [LANES];
    logic signed [ACC_W-1:0] grp_sum;

    for (genvar l = 0; l < LANES; l++) begin : g_mul
        assign prod[l] = lanes[l].en ? prod_t'($signed(lanes[l].smp)) * prod_t'($signed(lanes[l].cf))
                                     : '0;
    end

    always_comb begin
        grp_sum = acc;
        for (int l = 0; l < LANES; l++) begin
            grp_sum = grp_sum + {{(ACC_W-PW){prod[l][PW-1]}}, prod[l]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) acc <= '0;
        else if (acc_en)  acc <= grp_sum;
    end

    // R7: bits above the worst-case magnitude always copy the sign
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        ((&acc[ACC_W-1:GUARD]) || !(|acc[ACC_W-1:GUARD])));
endmodule

// File: rtl/wavelet_fir_conv.sv
module wavelet_fir_conv
    import wfir_pkg::*;
#(
    parameter int MAX_TAPS = 200,
    parameter int NUM_SETS = 121,
    parameter int ACC_W    = 40
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       sample_valid,
    input  logic [SAMPLE_W-1:0]        sample_in,
    input  logic                       start,
    input  logic [$clog2(NUM_SETS)-1:0] set_sel,
    input  logic [$clog2(MAX_TAPS+1)-1:0] tap_count,
    output logic                       result_valid,
    output logic [SAMPLE_W-1:0]        result
);
    localparam int SET_W  = $clog2(NUM_SETS);
    localparam int TAP_W  = $clog2(MAX_TAPS + 1);
    localparam int IDX_W  = TAP_W + 1;
    localparam int HALF_W = $clog2((MAX_TAPS + 1) / 2);
    localparam int GRP_W  = $clog2((MAX_TAPS + LANES - 1) / LANES + 1);
    localparam int HEAD_W = $clog2(MAX_TAPS);
    localparam int PTR_W  = HEAD_W + 1;

    state_e                    state;
    logic [GRP_W-1:0]          grp_q;
    logic [SET_W-1:0]          set_q;
    logic [TAP_W-1:0]          taps_q;
    logic [PTR_W-1:0]          base_q;
    logic                      done_q;
    logic [PTR_W-1:0]          newest;
    logic                      busy, accept, last_grp;
    logic [IDX_W-1:0]          j0, tz;

    logic [LANES-1:0]                  lane_en;
    logic [LANES-1:0][IDX_W-1:0]       offs;
    logic [LANES-1:0][HALF_W-1:0]      caddr;
    logic [LANES-1:0][SAMPLE_W-1:0]    smp_rd;
    logic [LANES-1:0][COEF_W-1:0]      cf_rd;
    lane_t [LANES-1:0]                 lanes;
    logic signed [ACC_W-1:0]           acc;

    assign busy     = (state == ST_RUN);
    assign accept   = start && !busy;
    assign tz       = IDX_W'(taps_q);
    assign j0       = IDX_W'(grp_q) * IDX_W'(LANES);
    assign last_grp = (j0 + IDX_W'(LANES)) >= tz;

    for (genvar l = 0; l < LANES; l++) begin : g_addr
        logic [IDX_W-1:0] j;
        logic [IDX_W:0]   j2;
        logic [IDX_W-1:0] k;
        assign j          = j0 + IDX_W'(l);
        assign j2         = {j, 1'b1};
        assign lane_en[l] = j < tz;
        assign k          = (j2 <= {1'b0, tz}) ? j : (tz - 1'b1 - j);
        assign offs[l]    = j;
        assign caddr[l]   = lane_en[l] ? HALF_W'(k) : '0;
        assign lanes[l]   = '{en: lane_en[l], smp: sample_t'(smp_rd[l]), cf: coef_t'(cf_rd[l])};

        // R3: a mirrored address never leaves the stored half
        a_r3_mirror_in_half: assert property (@(posedge clk) disable iff (rst)
            (busy && lane_en[l]) |-> (2 * int'(caddr[l]) + 1 <= int'(taps_q)));
    end

    wfir_sample_buf #(.PTR_W(PTR_W), .OFS_W(IDX_W)) u_buf (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (sample_valid),
        .wr_data (sample_t'(sample_in)),
        .newest  (newest),
        .base    (base_q),
        .offs    (offs),
        .rd      (smp_rd)
    );

    wfir_coef_rom #(.SET_W(SET_W), .HALF_W(HALF_W)) u_rom (
        .set_sel (set_q),
        .addr    (caddr),
        .coef    (cf_rd)
    );

    wfir_mac #(.ACC_W(ACC_W), .HEAD_W(HEAD_W)) u_mac (
        .clk    (clk),
        .rst    (rst),
        .clear  (accept),
        .acc_en (busy),
        .lanes  (lanes),
        .acc    (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            grp_q  <= '0;
            set_q  <= '0;
            taps_q <= '0;
            base_q <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    set_q  <= set_sel;
                    taps_q <= tap_count;
                    base_q <= newest;
                    grp_q  <= '0;
                    state  <= ST_RUN;
                end
                ST_RUN: begin
                    grp_q <= grp_q + 1'b1;
                    if (last_grp) begin
                        state  <= ST_IDLE;
                        done_q <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign result_valid = done_q;
    assign result       = acc[FRAC_SH +: SAMPLE_W];

    // R4: the strobe lasts one cycle and only ends a computation
    a_r4_valid_one_cycle: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);
    a_r4_valid_after_run: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> $past(busy));
    // R5 / R8: configuration and buffer origin stay frozen while running
    a_r5_cfg_held: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(set_q) && $stable(taps_q) && $stable(base_q)));
    // R6: the group counter never runs past the filter length
    a_r6_grp_bound: assert property (@(posedge clk) disable iff (rst)
        busy |-> ((j0 < tz) || (grp_q == '0)));
endmodule

// File: tb/tb_wavelet_fir_conv.sv
module tb_wavelet_fir_conv;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [15:0] sample_in = '0;
    logic        start = 1'b0;
    logic [6:0]  set_sel = '0;
    logic [7:0]  tap_count = '0;
    logic        result_valid;
    logic [15:0] result;

    int checks = 0;
    int fails  = 0;
    logic signed [15:0] hist [$];

    always #2 clk = ~clk;

    wavelet_fir_conv dut (
        .clk(clk), .rst(rst), .sample_valid(sample_valid), .sample_in(sample_in),
        .start(start), .set_sel(set_sel), .tap_count(tap_count),
        .result_valid(result_valid), .result(result)
    );

    function automatic longint ref_coef(int s, int k);
        int v;
        v = (29 * s + 7 * k * k + 3 * k + 5) & 12'hFFF;
        if (v >= 2048) v = v - 4096;
        return longint'(v);
    endfunction

    function automatic logic [15:0] ref_result(int s, int t);
        longint sum = 0;
        for (int j = 0; j < t; j++) begin
            int k;
            k = (2 * j + 1 <= t) ? j : t - 1 - j;
            sum += longint'(hist[j]) * ref_coef(s, k);
        end
        return 16'(sum >>> 11);
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] v);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in    = v;
        hist.push_front(signed'(v));
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    // runs one computation; optional stray start and late samples
    task automatic run(input int s, input int t, input string req,
                       input bit stray_start, input bit late_samples);
        logic [15:0] exp;
        logic [15:0] late [3];
        int cnt;
        int groups;
        exp    = ref_result(s, t);
        groups = (t + 4) / 5;
        if (groups == 0) groups = 1;
        @(negedge clk);
        set_sel   = 7'(s);
        tap_count = 8'(t);
        start     = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt   = 0;
        while (!result_valid && cnt < 300) begin
            start   = stray_start && (cnt == 2);
            set_sel = stray_start ? 7'(5) : 7'(s);
            tap_count = stray_start ? 8'(3) : 8'(t);
            sample_valid = late_samples && (cnt >= 1) && (cnt <= 3);
            if (sample_valid) begin
                late[cnt-1] = 16'($urandom);
                sample_in   = late[cnt-1];
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        sample_valid = 1'b0;
        check(result_valid, req, longint'(result_valid), 1);
        check(result == exp, req, longint'(signed'(result)), longint'(signed'(exp)));
        check(cnt == groups, {req, " R4 latency"}, cnt, groups);
        @(negedge clk);
        check(!result_valid, {req, " R4 single cycle"}, longint'(result_valid), 0);
        if (late_samples)
            for (int i = 0; i < 3; i++) hist.push_front(signed'(late[i]));
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check(!result_valid, "R1", longint'(result_valid), 0);
        end
    endtask

    task automatic t_fill_random(input int n);
        for (int i = 0; i < n; i++) push(16'($urandom));
    endtask

    task automatic t_extreme;
        for (int i = 0; i < 200; i++) push(16'h8000);
        run(77, 200, "R7 full-scale negative", 1'b0, 1'b0);
        for (int i = 0; i < 200; i++) push(16'h7FFF);
        run(120, 200, "R7 full-scale positive", 1'b0, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_fill_random(220);
        run(0,   200, "R2 R9 set 0",            1'b0, 1'b0);
        run(120, 200, "R2 R9 set 120",          1'b0, 1'b0);
        run(120, 200, "R5 stray start ignored", 1'b1, 1'b0);
        run(17,  7,   "R3 R6 odd length",       1'b0, 1'b0);
        run(63,  10,  "R3 even length",         1'b0, 1'b0);
        run(3,   1,   "R6 single tap",          1'b0, 1'b0);
        run(44,  13,  "R6 partial group",       1'b0, 1'b0);
        run(90,  150, "R8 late samples",        1'b0, 1'b1);
        run(90,  150, "R8 late samples now in", 1'b0, 1'b0);
        t_extreme();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule